// File: doc/BRIEF.md
# Digital loss-of-signal detector

This block monitors the recovered data stream of a line receiver, one pulse interval at a time. A strobe marks each interval. With the strobe come a flag that says whether a pulse was seen in the interval and a flag that reports an excessive-zero event. The block keeps a registered loss-of-signal flag. The flag is raised after a long run of intervals with no pulse. It is dropped only after an equally long run of intervals that are free of excessive-zero events. The two runs use different criteria on purpose, so that a marginal signal does not make the flag toggle.

An analog level detector elsewhere in the receiver can mute the data. While the mute input is high, every interval counts as empty. The block therefore declares loss of signal before the slower analog detector does. The mute also restarts the clear qualification, so recovery cannot begin until the mute is released.

Both run lengths are parameters, nominally 175 intervals with a usable tolerance of about 100 to 250. Any setting is clamped into the legal window of 10 to 255 intervals. A one-cycle change pulse goes with every transition of the flag and can feed interrupt logic.

Top module: `dlos_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `los` is 1 and `los_chg` is 0.
- R2: With `los` at 0, the clock edge that consumes the N-th consecutive strobed interval with no effective pulse sets `los` to 1. N is the clamped set threshold, 175 by default.
- R3: A strobed interval with `pulse_seen`=1 and `amute`=0 restarts the empty-interval run from zero.
- R4: With `los` at 1, the clock edge that consumes the M-th consecutive strobed interval with `exz_evt`=0 and `amute`=0 clears `los`. M is the clamped clear threshold, 175 by default. Counting starts with the first strobe after `los` was set.
- R5: A strobed interval with `exz_evt`=1 restarts the clear run from zero.
- R6: A strobed interval with `amute`=1 counts as empty even if `pulse_seen`=1, and it restarts the clear run.
- R7: In a cycle with `ivl_stb`=0, the values on `pulse_seen`, `exz_evt` and `amute` have no effect, and `los` does not change.
- R8: `los_chg` is 1 for exactly the one cycle in which `los` first shows a new value, and 0 at all other times.
- R9: A threshold parameter below 10 acts as 10, and one above 255 acts as 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ivl_stb | input | 1 | One pulse interval is presented this cycle |
| pulse_seen | input | 1 | A pulse was received in the interval |
| exz_evt | input | 1 | An excessive-zero event occurred in the interval |
| amute | input | 1 | Analog detector mutes the data |
| los | output | 1 | Registered loss-of-signal flag |
| los_chg | output | 1 | One-cycle pulse on each change of `los` |

## Verification
Two functions can fall in the same interval: a pulse that would restart the empty run, and an analog mute that forces the interval to count as empty. The bench sends strobes with `amute` and `pulse_seen` both high. It judges the interval by the cycle in which `los` is expected to rise, and the scoreboard computes that cycle from the threshold. In the same way, it sends `exz_evt` or `amute` just before the clear threshold is reached. It checks that `los` stays set and that the clear run starts again from zero, while a second instance built with out-of-range thresholds follows its clamped limits.

// File: rtl/dlos_pkg.sv
// Package: shared constants and helpers for the digital loss-of-signal detector.
// Assumes thresholds are given in pulse intervals.
package dlos_pkg;
    localparam int RUN_MIN = 10;
    localparam int RUN_MAX = 255;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    typedef enum logic {
        LINK_UP   = 1'b0,
        LINK_LOST = 1'b1
    } link_state_e;

    // Clamp a requested run length into the legal window.
    function automatic int clamp_run(input int req);
        if (req < RUN_MIN) return RUN_MIN;
        if (req > RUN_MAX) return RUN_MAX;
        return req;
    endfunction
endpackage

// File: rtl/dlos_run_counter.sv
// Module: counts consecutive qualifying strobed intervals.
// It reports `hit` combinationally on the strobe that completes LIMIT of them.
// Assumes LIMIT >= 2. The count returns to zero on hit, on restart or while held.
module dlos_run_counter #(
    parameter int LIMIT = 175,
    parameter int W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic restart,
    input  logic hold,
    output logic hit
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Flag the strobe that completes the run.
    always_comb begin
        hit = adv && !restart && !hold && (cnt == LAST);
    end

    // Advance, restart or hold the run count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || hit || (adv && restart)) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dlos_flag.sv
// Module: holds the loss-of-signal flag and makes its change pulse.
// Assumes set_hit arrives only while the link is up and clr_hit only while it is lost.
module dlos_flag
    import dlos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    output logic los,
    output logic los_chg
);
    link_state_e state;

    // Move between link up and link lost, pulsing on every move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LINK_LOST;
            los_chg <= 1'b0;
        end else if (state == LINK_UP && set_hit) begin
            state   <= LINK_LOST;
            los_chg <= 1'b1;
        end else if (state == LINK_LOST && clr_hit) begin
            state   <= LINK_UP;
            los_chg <= 1'b1;
        end else begin
            los_chg <= 1'b0;
        end
    end

    // Drive the flag from the state.
    always_comb begin
        los = (state == LINK_LOST);
    end
endmodule

// File: rtl/dlos_detector.sv
// Module: digital loss-of-signal detector (top).
// Raises `los` after SET_THRESH empty intervals. Drops it after CLR_THRESH intervals
// free of excessive-zero events. The analog mute forces intervals to count as empty and
// blocks the clear. Thresholds are clamped to the range 10..255.
module dlos_detector
    import dlos_pkg::*;
#(
    parameter int SET_THRESH = 175,
    parameter int CLR_THRESH = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ivl_stb,
    input  logic pulse_seen,
    input  logic exz_evt,
    input  logic amute,
    output logic los,
    output logic los_chg
);
    localparam int SET_EFF = clamp_run(SET_THRESH);
    localparam int CLR_EFF = clamp_run(CLR_THRESH);

    logic live_pulse;
    logic clr_break;
    logic set_hit;
    logic clr_hit;

    // Qualify the interval: the mute hides pulses and breaks clear runs.
    always_comb begin
        live_pulse = pulse_seen && !amute;
        clr_break  = exz_evt || amute;
    end

    dlos_run_counter #(.LIMIT(SET_EFF), .W(RUN_W)) u_zero_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (ivl_stb),
        .restart (live_pulse),
        .hold    (los),
        .hit     (set_hit)
    );

    dlos_run_counter #(.LIMIT(CLR_EFF), .W(RUN_W)) u_clear_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (ivl_stb),
        .restart (clr_break),
        .hold    (!los),
        .hit     (clr_hit)
    );

    dlos_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .los     (los),
        .los_chg (los_chg)
    );
endmodule

// File: rtl/dlos_detector_chk.sv
// Checker: temporal properties of the loss-of-signal detector ports, bound to the top.
module dlos_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic ivl_stb,
    input logic pulse_seen,
    input logic exz_evt,
    input logic amute,
    input logic los,
    input logic los_chg
);
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (los && !los_chg)); // R1
    AST_SET_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(ivl_stb)); // R2
    AST_SET_NO_LIVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> !$past(pulse_seen && !amute)); // R3
    AST_CLEAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(ivl_stb && !exz_evt && !amute)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ivl_stb |=> $stable(los)); // R7
    AST_CHG_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        los_chg |-> (los != $past(los))); // R8
    AST_MOVE_MEANS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        (los != $past(los)) |-> los_chg); // R8
    AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        los_chg |=> !los_chg); // R8
endmodule

bind dlos_detector dlos_detector_chk u_chk (.*);

// File: tb/dlos_detector_test.sv
`timescale 1ns/1ps
module dlos_detector_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ivl_stb = 1'b0, pulse_seen = 1'b0, exz_evt = 1'b0, amute = 1'b0;
    logic los, los_chg, los2, los_chg2;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dlos_detector uut (
        .clk(clk), .rst_n(rst_n), .ivl_stb(ivl_stb), .pulse_seen(pulse_seen),
        .exz_evt(exz_evt), .amute(amute), .los(los), .los_chg(los_chg)
    );

    // R9: out-of-range thresholds, expected to act as 10 (set) and 255 (clear)
    dlos_detector #(.SET_THRESH(3), .CLR_THRESH(400)) uut2 (
        .clk(clk), .rst_n(rst_n), .ivl_stb(ivl_stb), .pulse_seen(pulse_seen),
        .exz_evt(exz_evt), .amute(amute), .los(los2), .los_chg(los_chg2)
    );

    typedef struct {
        logic [1:0] los;
        logic [1:0] chg;
        string      tag;
    } exp_t;
    exp_t sb[$];

    int  set_lim[2] = '{175, 10};
    int  clr_lim[2] = '{175, 255};
    int  zrun[2];
    int  crun[2];
    bit  m_los[2];

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input bit rst_rel, input bit s, input bit p, input bit e,
                        input bit m, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = rst_rel; ivl_stb = s; pulse_seen = p; exz_evt = e; amute = m;
        for (int k = 0; k < 2; k++) begin
            it.chg[k] = 1'b0;
            if (!rst_rel) begin
                m_los[k] = 1'b1; zrun[k] = 0; crun[k] = 0;
            end else if (s) begin
                if (!m_los[k]) begin
                    crun[k] = 0;
                    if (p && !m) zrun[k] = 0;
                    else begin
                        zrun[k]++;
                        if (zrun[k] == set_lim[k]) begin
                            m_los[k] = 1'b1; it.chg[k] = 1'b1; zrun[k] = 0;
                        end
                    end
                end else begin
                    zrun[k] = 0;
                    if (e || m) crun[k] = 0;
                    else begin
                        crun[k]++;
                        if (crun[k] == clr_lim[k]) begin
                            m_los[k] = 1'b0; it.chg[k] = 1'b1; crun[k] = 0;
                        end
                    end
                end
            end
            it.los[k] = m_los[k];
        end
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic run(input int n, input bit s, input bit p, input bit e,
                       input bit m, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, s, p, e, m, tag);
    endtask

    // Monitor: after each edge, pop the expected item and compare both instances.
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (los !== it.los[0] || los_chg !== it.chg[0]) begin
                fails++;
                $display("FAIL %s uut los=%b chg=%b expected los=%b chg=%b",
                         it.tag, los, los_chg, it.los[0], it.chg[0]);
            end
            checks++;
            if (los2 !== it.los[1] || los_chg2 !== it.chg[1]) begin
                fails++;
                $display("FAIL R9 (%s) uut2 los=%b chg=%b expected los=%b chg=%b",
                         it.tag, los2, los_chg2, it.los[1], it.chg[1]);
            end
        end
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
        run(100, 1, 1, 0, 0, "R4");
        step(1'b1, 1, 1, 1, 0, "R5");               // exz restarts the clear run
        run(174, 1, 1, 0, 0, "R5");
        run(1, 1, 1, 0, 0, "R4");                   // uut clears here
        run(20, 0, 0, 1, 1, "R7");                  // no strobe: inputs ignored
        run(80, 1, 1, 0, 0, "R9");                  // uut2 reaches 255
        run(3, 1, 1, 0, 0, "R8");
        run(174, 1, 0, 0, 0, "R3");
        step(1'b1, 1, 1, 0, 0, "R3");               // pulse restarts the empty run
        run(174, 1, 0, 0, 0, "R3");
        run(1, 1, 0, 0, 0, "R2");                   // uut sets here
        run(170, 1, 1, 0, 0, "R4");
        step(1'b1, 1, 1, 0, 1, "R6");               // mute restarts the clear run
        run(174, 1, 1, 0, 0, "R6");
        run(1, 1, 1, 0, 0, "R6");
        run(300, 1, 1, 0, 0, "R4");
        run(60, 1, 0, 0, 0, "R7");
        run(10, 0, 1, 0, 0, "R7");
        run(115, 1, 1, 0, 1, "R6");                 // mute with pulse counts as empty
        run(10, 1, 1, 0, 0, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 5);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule